// File: doc/BRIEF.md
# Low-Power Oscillator Enable Controller

This block decides whether the enable of the low-power RC oscillator is on. The oscillator runs at about 512 kHz. It clocks the power-up timer, the watchdog and the clock monitor. The block contains that power-up timer. The timer counts oscillator periods, which reach the system clock domain as the synchronous input `osc_tick`. After power-on reset the enable is held on, so the timer can count. While the timer runs, the block holds the device reset output high.

When the timer expires, the block sets a sticky done flag and releases the device reset. From then on the enable stays on only while at least one of three requests is active: clock-failure monitoring, the watchdog, or selection of this oscillator as the system clock. The monitoring request does not count during sleep. The other two requests keep the oscillator on in sleep as well. The enable is worked out again in every cycle from the live request levels. A request that arrives later turns the oscillator back on in the same cycle.

Top module: `lposc_enable_ctrl`

## Requirements
- R1: While `rst` is high, `osc_en` is 1, `pwrup_done` is 0 and `dev_rst_o` is 1.
- R2: Until `pwrup_done` is 1, `osc_en` is 1 whatever the values of `fscm_req`, `wdt_req`, `sel_req` and `sleep_i`.
- R3: `pwrup_done` becomes 1 at the clock edge on which the PWRUP_TICKS-th rising transition of `osc_tick` since reset is sampled (default 64). A tick held high for several cycles counts once.
- R4: Once set, `pwrup_done` stays 1 under any further ticks or requests, and only `rst` clears it.
- R5: `dev_rst_o` is 1 exactly while `pwrup_done` is 0.
- R6: After expiry, `osc_en` is 1 whenever `wdt_req` is 1.
- R7: After expiry, `osc_en` is 1 whenever `sel_req` is 1.
- R8: After expiry, `fscm_req` alone holds `osc_en` at 1 while `sleep_i` is 0. With `sleep_i` at 1 it has no effect.
- R9: After expiry, with no request active, `osc_en` is 0. This holds from the same cycle in which `pwrup_done` rises.
- R10: After expiry, `osc_en` follows the request and sleep inputs combinationally, with no register delay.
- R11: `sleep_i` does not remove the effect of `wdt_req` or `sel_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| fscm_req | input | 1 | Clock-failure monitoring enabled |
| wdt_req | input | 1 | Watchdog enabled |
| sel_req | input | 1 | Low-power oscillator selected as system clock |
| sleep_i | input | 1 | Device is in sleep |
| osc_tick | input | 1 | Oscillator period indication, synchronous to `clk` |
| osc_en | output | 1 | Low-power oscillator enable |
| pwrup_done | output | 1 | Power-up timer expired (sticky) |
| dev_rst_o | output | 1 | Device reset, held until the timer expires |

## Verification
The bound checker tests the rules below in every cycle:
- the enable is forced on before expiry;
- the done flag is sticky;
- the reset output and the done flag are complementary;
- each request, and the sleep masking of monitoring, gives the right enable level after expiry;
- expiry comes after exactly the configured number of tick rises, counted independently.

Only the bench scenarios can show the rest:
- the exact edge on which expiry happens;
- that a widened tick is counted once;
- that a request raised between clock edges changes the enable at once;
- that a fresh reset clears the sticky flag and forces the enable on again.

// File: rtl/lposc_pkg.sv
package lposc_pkg;

    typedef struct packed {
        logic fscm;
        logic wdt;
        logic sel;
    } lposc_req_t;

    typedef enum logic [0:0] {
        ST_COUNT   = 1'b0,
        ST_EXPIRED = 1'b1
    } pwrt_state_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic logic keep_running(input lposc_req_t r, input logic slp);
        return (r.fscm & ~slp) | r.wdt | r.sel;
    endfunction

endpackage

// File: rtl/lposc_tick_edge.sv
module lposc_tick_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic rise_o
);
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick_i;
    end

    assign rise_o = tick_i & ~tick_q;
endmodule

// File: rtl/lposc_pwrt.sv
module lposc_pwrt
    import lposc_pkg::*;
#(
    parameter int unsigned TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic done_o
);
    localparam int unsigned CW = cnt_width(TICKS);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);
    localparam logic [CW-1:0] LAST = CW'(1);

    pwrt_state_e   state;
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_COUNT;
            remain <= LOAD;
        end else if (state == ST_COUNT && step_i) begin
            if (remain <= LAST) begin
                state  <= ST_EXPIRED;
                remain <= '0;
            end else begin
                remain <= remain - LAST;
            end
        end
    end

    assign done_o = (state == ST_EXPIRED);
endmodule

// File: rtl/lposc_req_eval.sv
module lposc_req_eval
    import lposc_pkg::*;
(
    input  lposc_req_t req_i,
    input  logic       sleep_i,
    input  logic       expired_i,
    output logic       en_o
);
    always_comb begin
        if (!expired_i) en_o = 1'b1;
        else            en_o = keep_running(req_i, sleep_i);
    end
endmodule

// File: rtl/lposc_enable_ctrl.sv
module lposc_enable_ctrl
    import lposc_pkg::*;
#(
    parameter int unsigned PWRUP_TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic fscm_req,
    input  logic wdt_req,
    input  logic sel_req,
    input  logic sleep_i,
    input  logic osc_tick,
    output logic osc_en,
    output logic pwrup_done,
    output logic dev_rst_o
);
    lposc_req_t req;
    logic       tick_rise;
    logic       expired;

    assign req.fscm = fscm_req;
    assign req.wdt  = wdt_req;
    assign req.sel  = sel_req;

    lposc_tick_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .tick_i (osc_tick),
        .rise_o (tick_rise)
    );

    lposc_pwrt #(.TICKS(PWRUP_TICKS)) u_pwrt (
        .clk    (clk),
        .rst    (rst),
        .step_i (tick_rise),
        .done_o (expired)
    );

    lposc_req_eval u_eval (
        .req_i     (req),
        .sleep_i   (sleep_i),
        .expired_i (expired),
        .en_o      (osc_en)
    );

    assign pwrup_done = expired;
    assign dev_rst_o  = ~expired;
endmodule

// File: rtl/lposc_enable_chk.sv
module lposc_enable_chk #(
    parameter int unsigned TICKS = 64
) (
    input logic clk,
    input logic rst,
    input logic fscm_req,
    input logic wdt_req,
    input logic sel_req,
    input logic sleep_i,
    input logic osc_tick,
    input logic osc_en,
    input logic pwrup_done,
    input logic dev_rst_o
);
    logic        tick_seen;
    int unsigned rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_seen <= 1'b0;
            rises     <= 0;
        end else begin
            tick_seen <= osc_tick;
            if (osc_tick && !tick_seen && rises < TICKS) rises <= rises + 1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (osc_en || !rst) );

    p_forced_on_r2: assert property (@(posedge clk) disable iff (rst)
        !pwrup_done |-> osc_en);

    p_expiry_count_r3: assert property (@(posedge clk) disable iff (rst)
        pwrup_done == (rises >= TICKS));

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        pwrup_done |=> pwrup_done);

    p_rst_until_done_r5: assert property (@(posedge clk) disable iff (rst)
        dev_rst_o != pwrup_done);

    p_wdt_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (pwrup_done && wdt_req) |-> osc_en);

    p_sel_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (pwrup_done && sel_req) |-> osc_en);

    p_fscm_awake_r8: assert property (@(posedge clk) disable iff (rst)
        (pwrup_done && fscm_req && !sleep_i) |-> osc_en);

    p_fscm_sleep_r8: assert property (@(posedge clk) disable iff (rst)
        (pwrup_done && fscm_req && sleep_i && !wdt_req && !sel_req) |-> !osc_en);

    p_idle_off_r9: assert property (@(posedge clk) disable iff (rst)
        (pwrup_done && !fscm_req && !wdt_req && !sel_req) |-> !osc_en);
endmodule

bind lposc_enable_ctrl lposc_enable_chk #(.TICKS(PWRUP_TICKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fscm_req   (fscm_req),
    .wdt_req    (wdt_req),
    .sel_req    (sel_req),
    .sleep_i    (sleep_i),
    .osc_tick   (osc_tick),
    .osc_en     (osc_en),
    .pwrup_done (pwrup_done),
    .dev_rst_o  (dev_rst_o)
);

// File: tb/lposc_enable_ctrl_test.sv
`timescale 1ns/1ps
module lposc_enable_ctrl_test;
    localparam int unsigned TICKS = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fscm_req = 1'b0, wdt_req = 1'b0, sel_req = 1'b0, sleep_i = 1'b0;
    logic osc_tick = 1'b0;
    logic osc_en, pwrup_done, dev_rst_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lposc_enable_ctrl #(.PWRUP_TICKS(TICKS)) uut (
        .clk(clk), .rst(rst), .fscm_req(fscm_req), .wdt_req(wdt_req),
        .sel_req(sel_req), .sleep_i(sleep_i), .osc_tick(osc_tick),
        .osc_en(osc_en), .pwrup_done(pwrup_done), .dev_rst_o(dev_rst_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic f, input logic w, input logic s, input logic slp);
        fscm_req = f; wdt_req = w; sel_req = s; sleep_i = slp;
        #0.5;
    endtask

    task automatic pulse(input int width);
        @(negedge clk); osc_tick = 1'b1;
        repeat (width) @(negedge clk);
        osc_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; osc_tick = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 osc_en in reset", osc_en, 1'b1);
        check("R1 pwrup_done in reset", pwrup_done, 1'b0);
        check("R1 dev_rst_o in reset", dev_rst_o, 1'b1);
        rst = 1'b0;
    endtask

    task automatic t_powerup_idle();
        do_reset();
        set_req(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < int'(TICKS) - 1; i++) begin
            pulse((i % 3 == 0) ? 4 : 1);
            if (i == 2) set_req(1'b0, 1'b0, 1'b0, 1'b1);
            if (i == 5) set_req(1'b0, 1'b0, 1'b0, 1'b0);
            #1;
            check("R2 enable forced during count", osc_en, 1'b1);
        end
        check("R3 held ticks count once, not yet done", pwrup_done, 1'b0);
        check("R5 reset held during count", dev_rst_o, 1'b1);
        @(negedge clk); osc_tick = 1'b1; #1;
        check("R3 not done before final edge", pwrup_done, 1'b0);
        check("R2 enable before final edge", osc_en, 1'b1);
        @(negedge clk); #1;
        check("R3 done after final tick edge", pwrup_done, 1'b1);
        check("R5 reset released at expiry", dev_rst_o, 1'b0);
        check("R9 idle enable drops at expiry", osc_en, 1'b0);
        osc_tick = 1'b0;
    endtask

    task automatic t_requests();
        set_req(1'b0, 1'b1, 1'b0, 1'b0); check("R6 watchdog keeps on", osc_en, 1'b1);
        set_req(1'b0, 1'b0, 1'b1, 1'b0); check("R7 selection keeps on", osc_en, 1'b1);
        set_req(1'b1, 1'b0, 1'b0, 1'b0); check("R8 monitoring keeps on", osc_en, 1'b1);
        set_req(1'b1, 1'b0, 1'b0, 1'b1); check("R8 monitoring ignored in sleep", osc_en, 1'b0);
        set_req(1'b0, 1'b1, 1'b0, 1'b1); check("R11 watchdog survives sleep", osc_en, 1'b1);
        set_req(1'b0, 1'b0, 1'b1, 1'b1); check("R11 selection survives sleep", osc_en, 1'b1);
        set_req(1'b0, 1'b0, 1'b0, 1'b0); check("R9 no request off", osc_en, 1'b0);
        @(negedge clk); #1;
        wdt_req = 1'b1; #0.2;
        check("R10 late request same cycle", osc_en, 1'b1);
        wdt_req = 1'b0; #0.2;
        check("R10 request removal same cycle", osc_en, 1'b0);
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 3; i++) pulse(1);
        set_req(1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk); #1;
        check("R4 done stays set", pwrup_done, 1'b1);
        check("R5 reset stays released", dev_rst_o, 1'b0);
        set_req(1'b0, 1'b0, 1'b0, 1'b0);
        do_reset();
        #1;
        check("R4 reset clears done", pwrup_done, 1'b0);
        check("R2 enable forced after new reset", osc_en, 1'b1);
    endtask

    task automatic t_expiry_with_watchdog();
        set_req(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < int'(TICKS); i++) pulse(2);
        #1;
        check("R3 done after full count", pwrup_done, 1'b1);
        check("R6 watchdog holds across expiry", osc_en, 1'b1);
        set_req(1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 off once watchdog drops", osc_en, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_powerup_idle();
        t_requests();
        t_sticky();
        t_expiry_with_watchdog();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule